// File: doc/BRIEF.md
# Snooping Three-State Cache Line Coherence Controller

This block keeps the coherence state of every line of a small direct-mapped write-back cache. The cache sits on a shared broadcast bus with other caches and uses an invalidation scheme. Each line is Invalid, Shared (clean, read-only) or Exclusive (the only copy, dirty and writable). The processor side presents a read or write with a block address and holds it until the controller answers with a done pulse and a hit flag. Misses request the bus. Once the bus is granted, the controller places a read miss, a write miss or a write-back of a dirty victim on it.

The controller also watches every command that other caches place on the bus. A foreign miss that matches one of its valid lines changes that line's state. When the matching line is Exclusive, the controller answers with a write-back of the block and an abort pulse, so that the memory read in progress is replaced by the owner's data. Data storage and memory belong to the environment. This block tracks only tags and states.

The bus is atomic. A line's state changes only in the cycle in which the bus is granted, or in the cycle in which a snooped miss is handled.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req`, `cpu_done` and `mem_abort` are 0, and `bus_cmd_o` is idle (00), so the first access to any address misses.
- R2: A processor read to an Invalid line raises `bus_req`. In the first granted cycle it issues a read miss (01) carrying the requested block address and the cache's own ID on `bus_src_o`, and the line becomes Shared. The address split is index = low `IDX_W` bits and tag = the remaining bits.
- R3: A processor write to an Invalid line or to a Shared line is treated as a miss. It issues a write miss (10), and the line becomes Exclusive.
- R4: A read to a Shared or Exclusive line, or a write to an Exclusive line, with a matching tag is a hit. It produces `cpu_done`=1 with `cpu_hit`=1 one cycle after acceptance and places no command on the bus.
- R5: A miss whose index holds an Exclusive line with another tag issues a write-back (11) of the old block address in the first granted cycle and the new miss in the next cycle. A Shared victim produces no write-back.
- R6: A foreign write miss that matches a Shared or Exclusive line makes it Invalid. If the line was Exclusive, the next cycle shows a write-back of that block on `bus_cmd_o` together with a `mem_abort` pulse.
- R7: A foreign read miss that matches an Exclusive line produces a write-back plus `mem_abort` and leaves the line Shared. A foreign read miss to a Shared line changes nothing.
- R8: No line state changes, and no miss is issued, while the request waits for `bus_gnt`. A snooped miss that hits the waiting line's index is handled first. The request is then re-evaluated against the updated line when the grant comes.
- R9: Snooped commands whose `snp_src` equals the cache's own ID are ignored, and so are snooped write-back commands.
- R10: A snooped miss that hits a valid line stalls the processor port for that cycle. A snooped command that matches no line does not stall it.
- R11: `cpu_done` with `cpu_hit`=0 appears only in the cycle in which the read miss or write miss is on `bus_cmd_o`, and `bus_req` falls at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Valid with `cpu_done`: 1 = hit, 0 = miss serviced |
| bus_req | output | 1 | Bus arbitration request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | Issued command: 00 idle, 01 read miss, 10 write miss, 11 write-back |
| bus_addr_o | output | ADDR_W | Block address of the issued command |
| bus_src_o | output | ID_W | Own cache ID attached to issued commands |
| mem_abort | output | 1 | Pulse: the memory access is aborted and this cache supplies the block |
| snp_cmd | input | 2 | Command observed on the bus |
| snp_addr | input | ADDR_W | Block address observed on the bus |
| snp_src | input | ID_W | Source ID observed on the bus |

## Verification
Three pairs of events can collide in a single cycle. A snooped hit can arrive together with a new processor request. A snooped hit can also arrive while a miss is waiting for the grant and hit that miss's own index. A snooped command can also match nothing, or come from this cache itself. The bench presents the snoop and the processor hit on the same falling edge and measures the completion latency, which must be two cycles instead of one. Against this, a snoop to an unmatched address must leave the latency at one cycle. For the waiting case, a dirty line is invalidated by a foreign write miss while the grant is withheld. The bench then checks that the later grant produces only the new read miss, with no write-back of a block that the snoop has already flushed.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_t;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'b00,
    BC_RDMISS = 2'b01,
    BC_WRMISS = 2'b10,
    BC_WBACK  = 2'b11
  } bus_cmd_t;

  // state a valid line moves to after a matching foreign miss
  function automatic line_st_t snoop_next(line_st_t cur, bus_cmd_t cmd);
    if (cmd == BC_WRMISS) return LS_INV;
    if (cmd == BC_RDMISS && cur == LS_EXC) return LS_SHR;
    return cur;
  endfunction

  // processor access satisfied locally without the bus
  function automatic logic cpu_hits(line_st_t cur, logic tag_eq, logic we);
    if (!tag_eq) return 1'b0;
    return we ? (cur == LS_EXC) : (cur != LS_INV);
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_t         ra_st,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_t         rb_st,
  input  logic             w_en,
  input  logic [IDX_W-1:0] w_idx,
  input  logic             w_tag_en,
  input  logic [TAG_W-1:0] w_tag,
  input  line_st_t         w_st
);
  localparam int LINES = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [LINES];
  line_st_t         st_q  [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]  <= LS_INV;
        tag_q[g] <= '0;
      end else if (w_en && w_idx == IDX_W'(g)) begin
        st_q[g] <= w_st;
        if (w_tag_en) tag_q[g] <= w_tag;
      end
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_src,
  output logic [IDX_W-1:0]  snp_idx,
  input  logic [ADDR_W-IDX_W-1:0] line_tag,
  input  line_st_t          line_st,
  output logic              snp_hit,
  output logic              snp_flush,
  output line_st_t          snp_next
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [ID_W-1:0] OWN = ID_W'(MY_ID);

  bus_cmd_t         cmd;
  logic [TAG_W-1:0] snp_tag;
  logic             is_miss;
  logic             foreign;

  assign cmd     = bus_cmd_t'(snp_cmd);
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];
  assign is_miss = (cmd == BC_RDMISS) || (cmd == BC_WRMISS);
  assign foreign = (snp_src != OWN);

  assign snp_hit   = is_miss && foreign && (line_st != LS_INV) && (line_tag == snp_tag);
  assign snp_flush = snp_hit && (line_st == LS_EXC);
  assign snp_next  = snoop_next(line_st, cmd);
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              cpu_hit,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [ID_W-1:0]   bus_src_o,
  output logic              mem_abort,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ID_W-1:0]   snp_src
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic {F_IDLE, F_WAIT} fsm_t;

  fsm_t              fsm_q;
  logic              op_we_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic              done_q, hit_q, abort_q;
  bus_cmd_t          cmd_q;
  logic [ADDR_W-1:0] baddr_q;

  // lookup port A follows the processor, port B follows the snooped address
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_we;
  logic [TAG_W-1:0]  ra_tag, rb_tag;
  line_st_t          ra_st, rb_st;
  logic [IDX_W-1:0]  snp_idx;
  logic              snp_hit, snp_flush;
  line_st_t          snp_next;

  // named events used by the assertions
  logic tag_eq, hit_now, accept, grant_use, victim_dirty, req_restart;

  logic             w_en, w_tag_en;
  logic [IDX_W-1:0] w_idx;
  line_st_t         w_st;

  assign cur_addr = (fsm_q == F_WAIT) ? op_addr_q : cpu_addr;
  assign cur_we   = (fsm_q == F_WAIT) ? op_we_q   : cpu_we;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(cur_addr[IDX_W-1:0]), .ra_tag(ra_tag), .ra_st(ra_st),
    .rb_idx(snp_idx), .rb_tag(rb_tag), .rb_st(rb_st),
    .w_en(w_en), .w_idx(w_idx), .w_tag_en(w_tag_en),
    .w_tag(cur_addr[ADDR_W-1:IDX_W]), .w_st(w_st)
  );

  msi_snoop_unit #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src),
    .snp_idx(snp_idx), .line_tag(rb_tag), .line_st(rb_st),
    .snp_hit(snp_hit), .snp_flush(snp_flush), .snp_next(snp_next)
  );

  assign tag_eq       = (ra_tag == cur_addr[ADDR_W-1:IDX_W]);
  assign hit_now      = cpu_hits(ra_st, tag_eq, cur_we);
  assign accept       = (fsm_q == F_IDLE) && cpu_req && !done_q && !snp_hit;
  assign grant_use    = (fsm_q == F_WAIT) && bus_gnt && !snp_hit;
  assign victim_dirty = (ra_st == LS_EXC) && !tag_eq;
  assign req_restart  = (fsm_q == F_WAIT) && snp_hit &&
                        (snp_idx == op_addr_q[IDX_W-1:0]);

  // single write port: a snoop hit and a granted miss never share a cycle
  always_comb begin
    w_en     = 1'b0;
    w_tag_en = 1'b0;
    w_idx    = cur_addr[IDX_W-1:0];
    w_st     = LS_INV;
    if (snp_hit) begin
      w_en  = 1'b1;
      w_idx = snp_idx;
      w_st  = snp_next;
    end else if (grant_use && victim_dirty) begin
      w_en = 1'b1;
      w_st = LS_INV;
    end else if (grant_use) begin
      w_en     = 1'b1;
      w_tag_en = 1'b1;
      w_st     = op_we_q ? LS_EXC : LS_SHR;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm_q     <= F_IDLE;
      op_we_q   <= 1'b0;
      op_addr_q <= '0;
      done_q    <= 1'b0;
      hit_q     <= 1'b0;
      abort_q   <= 1'b0;
      cmd_q     <= BC_IDLE;
      baddr_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      hit_q   <= 1'b0;
      abort_q <= 1'b0;
      cmd_q   <= BC_IDLE;
      if (snp_flush) begin
        cmd_q   <= BC_WBACK;
        baddr_q <= snp_addr;
        abort_q <= 1'b1;
      end
      case (fsm_q)
        F_IDLE: if (accept) begin
          if (hit_now) begin
            done_q <= 1'b1;
            hit_q  <= 1'b1;
          end else begin
            fsm_q     <= F_WAIT;
            op_we_q   <= cpu_we;
            op_addr_q <= cpu_addr;
          end
        end
        F_WAIT: if (grant_use) begin
          if (victim_dirty) begin
            cmd_q   <= BC_WBACK;
            baddr_q <= {ra_tag, op_addr_q[IDX_W-1:0]};
          end else begin
            cmd_q   <= op_we_q ? BC_WRMISS : BC_RDMISS;
            baddr_q <= op_addr_q;
            fsm_q   <= F_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign cpu_done   = done_q;
  assign cpu_hit    = hit_q;
  assign bus_req    = (fsm_q == F_WAIT);
  assign bus_cmd_o  = cmd_q;
  assign bus_addr_o = baddr_q;
  assign bus_src_o  = ID_W'(MY_ID);
  assign mem_abort  = abort_q;

  // R4: a hit completes with nothing on the bus
  a_r4_hit_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && cpu_hit) |-> (bus_cmd_o == BC_IDLE));

  // R11: a serviced miss completes together with its miss command
  a_r11_miss_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_done && !cpu_hit) |-> (bus_cmd_o == BC_RDMISS || bus_cmd_o == BC_WRMISS));

  // R6, R7: an abort always travels with a write-back of the block
  a_r6_abort_is_wback: assert property (@(posedge clk) disable iff (!rst_n)
    mem_abort |-> (bus_cmd_o == BC_WBACK));

  // R9: own-ID commands never provoke a flush
  a_r9_own_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_src == ID_W'(MY_ID)) |=> !mem_abort);

  // R10: a snoop hit stalls the processor port for that cycle
  a_r10_snoop_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |=> !cpu_done);

  // R8: a restarted request issues no miss in the cycle of the snoop
  a_r8_restart_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
    req_restart |=> (bus_cmd_o != BC_RDMISS && bus_cmd_o != BC_WRMISS));

  // R11: bus request drops only when the miss goes out
  a_r11_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> (cpu_done && !cpu_hit));
endmodule

// File: tb/sim_msi_line_ctrl.sv
module sim_msi_line_ctrl;
  localparam int AW = 12;
  localparam int IW = 3;
  localparam int DW = 2;
  localparam logic [DW-1:0] ME = 2'd1;
  localparam logic [DW-1:0] OTHER = 2'd2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          cpu_done, cpu_hit, bus_req;
  logic          bus_gnt = 1'b0;
  logic [1:0]    bus_cmd_o;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_src_o;
  logic          mem_abort;
  logic [1:0]    snp_cmd = 2'b00;
  logic [AW-1:0] snp_addr = '0;
  logic [DW-1:0] snp_src = '0;

  always #2 clk = ~clk;

  msi_line_ctrl #(.ADDR_W(AW), .IDX_W(IW), .ID_W(DW), .MY_ID(1)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cmd_o(bus_cmd_o), .bus_addr_o(bus_addr_o), .bus_src_o(bus_src_o),
    .mem_abort(mem_abort), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_src(snp_src)
  );

  localparam logic [1:0] C_IDLE = 2'b00, C_RD = 2'b01, C_WR = 2'b10, C_WB = 2'b11;
  localparam logic [AW-1:0] A = 12'h013, B = 12'h023, C = 12'h015, D = 12'h025, Z = 12'h0F7;

  int checks = 0, errors = 0, cycles = 0;
  logic          got_hit;
  int            got_lat;
  int            log_n;
  logic [1:0]    log_cmd [4];
  logic [AW-1:0] log_addr [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // full access with a cooperative arbiter; logs every command seen
  task automatic access(input logic we, input logic [AW-1:0] addr);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; log_n = 0; got_hit = 1'b0; got_lat = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (bus_cmd_o != C_IDLE && log_n < 4) begin
        log_cmd[log_n] = bus_cmd_o; log_addr[log_n] = bus_addr_o; log_n++;
      end
      if (cpu_done) begin
        got_hit = cpu_hit; got_lat = i + 1;
        cpu_req = 1'b0; bus_gnt = 1'b0;
        break;
      end
      bus_gnt = bus_req;
    end
  endtask

  task automatic expect_hit(input logic we, input logic [AW-1:0] addr, input string req);
    access(we, addr);
    chk(got_hit == 1'b1, req, "hit flag", got_hit, 1);
    chk(log_n == 0, req, "bus commands on hit", log_n, 0);
    chk(got_lat == 1, req, "hit latency", got_lat, 1);
  endtask

  task automatic expect_miss(input logic we, input logic [AW-1:0] addr,
                             input bit wb, input logic [AW-1:0] wb_addr, input string req);
    logic [1:0] mc;
    mc = we ? C_WR : C_RD;
    access(we, addr);
    chk(got_hit == 1'b0, req, "miss flag", got_hit, 0);
    chk(log_n == (wb ? 2 : 1), req, "command count", log_n, wb ? 2 : 1);
    if (wb && log_n == 2) begin
      chk(log_cmd[0] == C_WB, req, "victim write-back cmd", log_cmd[0], C_WB);
      chk(log_addr[0] == wb_addr, req, "victim address", log_addr[0], wb_addr);
    end
    if (log_n >= 1) begin
      chk(log_cmd[log_n-1] == mc, req, "miss cmd", log_cmd[log_n-1], mc);
      chk(log_addr[log_n-1] == addr, req, "miss address", log_addr[log_n-1], addr);
    end
    chk(bus_src_o == ME, req, "source id", bus_src_o, ME);
  endtask

  // one-cycle snoop; outputs of its handling are visible one edge later
  task automatic snoop(input logic [1:0] cmd, input logic [AW-1:0] addr,
                       input logic [DW-1:0] src, input bit flush, input string req);
    @(negedge clk);
    snp_cmd = cmd; snp_addr = addr; snp_src = src;
    @(negedge clk);
    snp_cmd = C_IDLE;
    chk(mem_abort == flush, req, "abort pulse", mem_abort, flush);
    chk(bus_cmd_o == (flush ? C_WB : C_IDLE), req, "snoop response cmd", bus_cmd_o,
        flush ? C_WB : C_IDLE);
    if (flush) chk(bus_addr_o == addr, req, "flushed address", bus_addr_o, addr);
  endtask

  task automatic t_reset;
    chk(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
    chk(cpu_done == 1'b0, "R1", "cpu_done after reset", cpu_done, 0);
    chk(mem_abort == 1'b0, "R1", "mem_abort after reset", mem_abort, 0);
    chk(bus_cmd_o == C_IDLE, "R1", "bus idle after reset", bus_cmd_o, C_IDLE);
    expect_miss(1'b0, A, 1'b0, '0, "R1 R2");
  endtask

  task automatic t_local;
    expect_hit(1'b0, A, "R4");            // Shared read hit
    expect_miss(1'b1, A, 1'b0, '0, "R3"); // Shared write upgrades
    expect_hit(1'b1, A, "R4");
    expect_hit(1'b0, A, "R4");
  endtask

  task automatic t_conflict;
    expect_miss(1'b0, B, 1'b1, A, "R5");  // dirty A evicted first
    expect_miss(1'b0, A, 1'b0, '0, "R5"); // clean B dropped silently
  endtask

  task automatic t_snoop;
    snoop(C_RD, A, OTHER, 1'b0, "R7");
    expect_hit(1'b0, A, "R7");
    snoop(C_WR, A, OTHER, 1'b0, "R6");
    expect_miss(1'b0, A, 1'b0, '0, "R6");
    expect_miss(1'b1, C, 1'b0, '0, "R3");
    snoop(C_RD, C, OTHER, 1'b1, "R7");
    expect_hit(1'b0, C, "R7");
    expect_miss(1'b1, C, 1'b0, '0, "R7");
    snoop(C_WR, C, OTHER, 1'b1, "R6");
    expect_miss(1'b1, C, 1'b0, '0, "R6");
  endtask

  task automatic t_own_id;
    snoop(C_WR, C, ME, 1'b0, "R9");
    expect_hit(1'b1, C, "R9");
    snoop(C_WB, C, OTHER, 1'b0, "R9");
    expect_hit(1'b1, C, "R9");
  endtask

  task automatic t_restart;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = D;
    @(negedge clk);
    chk(bus_req == 1'b1, "R8", "request raised", bus_req, 1);
    @(negedge clk);
    chk(bus_cmd_o == C_IDLE, "R8", "nothing issued before grant", bus_cmd_o, C_IDLE);
    snp_cmd = C_WR; snp_addr = C; snp_src = OTHER;
    @(negedge clk);
    snp_cmd = C_IDLE;
    chk(mem_abort == 1'b1 && bus_cmd_o == C_WB, "R8", "snoop flushed first", bus_cmd_o, C_WB);
    chk(bus_req == 1'b1, "R8", "request still pending", bus_req, 1);
    bus_gnt = 1'b1;
    @(negedge clk);
    chk(bus_cmd_o == C_RD, "R8", "only read miss after restart", bus_cmd_o, C_RD);
    chk(bus_addr_o == D, "R8", "restarted address", bus_addr_o, D);
    chk(cpu_done == 1'b1 && cpu_hit == 1'b0, "R8", "restarted completion", cpu_done, 1);
    cpu_req = 1'b0; bus_gnt = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b0, "R11", "request dropped", bus_req, 0);
    expect_hit(1'b0, D, "R8");
  endtask

  task automatic t_priority;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A;
    snp_cmd = C_RD; snp_addr = D; snp_src = OTHER;
    @(negedge clk);
    snp_cmd = C_IDLE;
    chk(cpu_done == 1'b0, "R10", "stalled by snoop hit", cpu_done, 0);
    @(negedge clk);
    chk(cpu_done == 1'b1 && cpu_hit == 1'b1, "R10", "hit after stall", cpu_done, 1);
    cpu_req = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A;
    snp_cmd = C_WR; snp_addr = Z; snp_src = OTHER;
    @(negedge clk);
    snp_cmd = C_IDLE;
    chk(cpu_done == 1'b1 && cpu_hit == 1'b1, "R10", "unmatched snoop no stall", cpu_done, 1);
    cpu_req = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_local;
    t_conflict;
    t_snoop;
    t_own_id;
    t_restart;
    t_priority;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule